// File: doc/BRIEF.md
# Store Request Formatter

This block turns one decoded integer store into a write request for a 64-bit memory port. It works out the effective address from a base register and either a signed displacement or an index register. It shifts the selected low-order bytes of the source register onto the correct byte lanes of the data bus, with an optional byte-reversed order, and it sets the matching byte enables. For the update forms it also produces a base-register writeback that carries the effective address.

Operand checks run on every accepted operation. The block flags encodings that are not legal, and it flags accesses that would cross an aligned doubleword. In either case it issues neither the memory write nor the writeback. One registered stage sits between an input valid/ready pair and an output valid/ready pair. An operation that is accepted on one clock edge is presented on the next cycle, and it stays there until the consumer takes it.

Top module: `store_req_fmt`

## Requirements
- R1: After a synchronous active-high reset, `o_valid` is 0 and `i_ready` is 1.
- R2: When `i_update` is 0 and `i_base_idx` is 0, the base operand is the value zero and `i_base_val` is ignored. In every other case the base operand is `i_base_val`.
- R3: `o_addr` is the base operand plus the 16-bit `i_disp` sign-extended to 64 bits when `i_indexed` is 0, or plus `i_index_val` when `i_indexed` is 1. The sum is taken modulo 2^64.
- R4: For a doubleword (`i_size`=3) displacement access, the two low bits of `i_disp` are treated as zero before sign extension.
- R5: Sizes are coded 0=byte, 1=halfword, 2=word, 3=doubleword, so n = 1, 2, 4 or 8 bytes. A normal store writes the lowest n bytes of `i_src`, with its most significant byte at the lowest address. Address offset k = `o_addr[2:0]`+j uses bus lane k, which is `o_data[63-8k:56-8k]`. Lanes that are not written carry zero.
- R6: `o_be[k]` is 1 exactly for the lanes that are written, that is offsets `o_addr[2:0]` through `o_addr[2:0]`+n-1. `o_be` and `o_data` are all zero whenever `o_req` is 0.
- R7: A valid update store (`i_update`=1) uses `i_base_val` as the base. It sets `o_wb`=1, `o_wb_idx`=`i_base_idx` and `o_wb_val`=`o_addr`. Non-update stores leave `o_wb` at 0.
- R8: With `i_brev`=1, the n source bytes are written in reversed order, so the least significant byte of `i_src` lands at the lowest address.
- R9: The form is invalid when any of these holds: update with base index 0; byte reverse with displacement addressing; byte reverse with update. An invalid form sets `o_bad_form`=1, `o_req`=0 and `o_wb`=0.
- R10: A legal form with `o_addr[2:0]`+n > 8 sets `o_misalign`=1 and `o_req`=0 and `o_wb`=0. `o_misalign` is 0 for invalid forms.
- R11: `i_ready` = !`o_valid` || `o_ready`. An operation accepted at an edge appears on the outputs after that edge. While `o_valid` is 1 and `o_ready` is 0, the outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Store operation offered |
| i_ready | output | 1 | Operation can be taken |
| i_src | input | 64 | Source register value |
| i_base_idx | input | 5 | Base register number |
| i_base_val | input | 64 | Base register contents |
| i_index_val | input | 64 | Index register contents |
| i_disp | input | 16 | Signed displacement field |
| i_indexed | input | 1 | 1 selects index register, 0 selects displacement |
| i_size | input | 2 | Access size code |
| i_update | input | 1 | Write effective address back to base register |
| i_brev | input | 1 | Byte-reversed store |
| o_valid | output | 1 | Result present |
| o_ready | input | 1 | Consumer takes the result |
| o_req | output | 1 | Memory write to perform |
| o_addr | output | 64 | Effective address |
| o_be | output | 8 | Byte-lane enables, bit k for address offset k |
| o_data | output | 64 | Lane-aligned write data |
| o_wb | output | 1 | Base-register writeback to perform |
| o_wb_idx | output | 5 | Register to write back |
| o_wb_val | output | 64 | Value to write back |
| o_bad_form | output | 1 | Illegal encoding seen |
| o_misalign | output | 1 | Access crosses a doubleword |

## Verification
Several cases would go wrong quietly, so the stimulus targets them directly. One is base index 0 with and without update: a design that swaps the zero substitution produces an address offset by the base value, or accepts an illegal form. Another is doubleword displacements whose low two bits are set: a design that fails to clear them produces an address off by 1 to 3. Byte-reversed stores of every size at non-zero offsets expose a lane or byte-order slip as scrambled data. Accesses that end exactly on, or one byte past, a doubleword edge expose an off-by-one in the crossing test. A random backpressure pattern on `o_ready` catches a result that is dropped, duplicated or changed while it is held.

// File: rtl/stfmt_pkg.sv
package stfmt_pkg;

    localparam int ST_XLEN   = 64;
    localparam int ST_RIDX_W = 5;
    localparam int ST_DISP_W = 16;
    localparam int ST_NB     = ST_XLEN / 8;
    localparam int ST_OFFW   = $clog2(ST_NB);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } size_e;

    typedef struct packed {
        logic                 req;
        logic [ST_XLEN-1:0]   addr;
        logic [ST_NB-1:0]     be;
        logic [ST_XLEN-1:0]   data;
        logic                 wb;
        logic [ST_RIDX_W-1:0] wb_idx;
        logic                 bad_form;
        logic                 misalign;
    } result_t;

    function automatic logic [ST_OFFW:0] size_bytes(input size_e sz);
        return (ST_OFFW+1)'(1) << sz;
    endfunction

endpackage

// File: rtl/stfmt_agen.sv
module stfmt_agen
    import stfmt_pkg::*;
#(
    parameter int XLEN   = ST_XLEN,
    parameter int RIDX_W = ST_RIDX_W,
    parameter int DISP_W = ST_DISP_W
) (
    input  logic [XLEN-1:0]   base_val,
    input  logic [RIDX_W-1:0] base_idx,
    input  logic [XLEN-1:0]   index_val,
    input  logic [DISP_W-1:0] disp,
    input  logic              indexed,
    input  logic              update,
    input  size_e             size,
    output logic [XLEN-1:0]   ea
);
    localparam int EXT_W = XLEN - DISP_W;

    logic [XLEN-1:0]   base_op;
    logic [DISP_W-1:0] disp_adj;
    logic [XLEN-1:0]   offset;

    always_comb begin
        // zero substitution applies only without update
        if (!update && (base_idx == '0))
            base_op = '0;
        else
            base_op = base_val;

        // doubleword displacement forms carry a word-scaled field
        disp_adj = disp;
        if (size == SZ_DBL)
            disp_adj[1:0] = 2'b00;

        if (indexed)
            offset = index_val;
        else
            offset = {{EXT_W{disp_adj[DISP_W-1]}}, disp_adj};

        ea = base_op + offset;
    end

endmodule

// File: rtl/stfmt_lane.sv
module stfmt_lane
    import stfmt_pkg::*;
#(
    parameter int XLEN = ST_XLEN,
    parameter int NB   = XLEN / 8,
    parameter int OFFW = $clog2(NB)
) (
    input  logic [XLEN-1:0] src,
    input  size_e           size,
    input  logic            brev,
    input  logic [OFFW-1:0] offset,
    output logic [XLEN-1:0] data,
    output logic [NB-1:0]   be,
    output logic            crosses
);
    logic [OFFW:0] nbytes;

    always_comb begin
        nbytes  = size_bytes(size);
        crosses = ({1'b0, offset} + nbytes) > (OFFW+1)'(NB);
    end

    for (genvar k = 0; k < NB; k++) begin : g_lane
        int              rel;
        logic            hit;
        logic [OFFW-1:0] sel;

        always_comb begin
            rel = k - int'(offset);
            hit = (rel >= 0) && (rel < int'(nbytes));
            // normal order puts the most significant chosen byte first
            if (brev)
                sel = OFFW'(rel);
            else
                sel = OFFW'(int'(nbytes) - 1 - rel);
            be[k] = hit;
            data[XLEN-1-8*k -: 8] = hit ? src[8*sel +: 8] : 8'h00;
        end
    end

endmodule

// File: rtl/stfmt_ctrl.sv
module stfmt_ctrl
    import stfmt_pkg::*;
#(
    parameter int RIDX_W = ST_RIDX_W
) (
    input  logic [RIDX_W-1:0] base_idx,
    input  logic              indexed,
    input  logic              update,
    input  logic              brev,
    input  logic              crosses,
    output logic              bad_form,
    output logic              misalign,
    output logic              req,
    output logic              wb
);
    logic upd_r0;
    logic rev_disp;
    logic rev_upd;

    always_comb begin
        upd_r0   = update && (base_idx == '0);
        rev_disp = brev && !indexed;
        rev_upd  = brev && update;
        bad_form = upd_r0 || rev_disp || rev_upd;
        misalign = !bad_form && crosses;
        req      = !bad_form && !crosses;
        wb       = req && update;
    end

endmodule

// File: rtl/store_req_fmt.sv
module store_req_fmt
    import stfmt_pkg::*;
#(
    parameter int XLEN   = ST_XLEN,
    parameter int RIDX_W = ST_RIDX_W,
    parameter int DISP_W = ST_DISP_W,
    parameter int NB     = XLEN / 8,
    parameter int OFFW   = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              i_valid,
    output logic              i_ready,
    input  logic [XLEN-1:0]   i_src,
    input  logic [RIDX_W-1:0] i_base_idx,
    input  logic [XLEN-1:0]   i_base_val,
    input  logic [XLEN-1:0]   i_index_val,
    input  logic [DISP_W-1:0] i_disp,
    input  logic              i_indexed,
    input  logic [1:0]        i_size,
    input  logic              i_update,
    input  logic              i_brev,
    output logic              o_valid,
    input  logic              o_ready,
    output logic              o_req,
    output logic [XLEN-1:0]   o_addr,
    output logic [NB-1:0]     o_be,
    output logic [XLEN-1:0]   o_data,
    output logic              o_wb,
    output logic [RIDX_W-1:0] o_wb_idx,
    output logic [XLEN-1:0]   o_wb_val,
    output logic              o_bad_form,
    output logic              o_misalign
);
    size_e           size_in;
    logic [XLEN-1:0] ea;
    logic [XLEN-1:0] lane_data;
    logic [NB-1:0]   lane_be;
    logic            crosses;
    logic            bad_form;
    logic            misalign;
    logic            req;
    logic            wb;
    logic            accept;
    result_t         nxt;
    result_t         cur;
    logic            valid_q;

    assign size_in = size_e'(i_size);

    stfmt_agen #(.XLEN(XLEN), .RIDX_W(RIDX_W), .DISP_W(DISP_W)) u_agen (
        .base_val  (i_base_val),
        .base_idx  (i_base_idx),
        .index_val (i_index_val),
        .disp      (i_disp),
        .indexed   (i_indexed),
        .update    (i_update),
        .size      (size_in),
        .ea        (ea)
    );

    stfmt_lane #(.XLEN(XLEN), .NB(NB), .OFFW(OFFW)) u_lane (
        .src     (i_src),
        .size    (size_in),
        .brev    (i_brev),
        .offset  (ea[OFFW-1:0]),
        .data    (lane_data),
        .be      (lane_be),
        .crosses (crosses)
    );

    stfmt_ctrl #(.RIDX_W(RIDX_W)) u_ctrl (
        .base_idx (i_base_idx),
        .indexed  (i_indexed),
        .update   (i_update),
        .brev     (i_brev),
        .crosses  (crosses),
        .bad_form (bad_form),
        .misalign (misalign),
        .req      (req),
        .wb       (wb)
    );

    always_comb begin
        nxt          = '0;
        nxt.req      = req;
        nxt.addr     = ea;
        nxt.be       = req ? lane_be : '0;
        nxt.data     = req ? lane_data : '0;
        nxt.wb       = wb;
        nxt.wb_idx   = i_base_idx;
        nxt.bad_form = bad_form;
        nxt.misalign = misalign;
    end

    assign i_ready = !valid_q || o_ready;
    assign accept  = i_valid && i_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            cur     <= '0;
        end else begin
            if (accept) begin
                valid_q <= 1'b1;
                cur     <= nxt;
            end else if (o_ready) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign o_valid    = valid_q;
    assign o_req      = cur.req;
    assign o_addr     = cur.addr;
    assign o_be       = cur.be;
    assign o_data     = cur.data;
    assign o_wb       = cur.wb;
    assign o_wb_idx   = cur.wb_idx;
    assign o_wb_val   = cur.addr;
    assign o_bad_form = cur.bad_form;
    assign o_misalign = cur.misalign;

endmodule

// File: rtl/stfmt_chk.sv
module stfmt_chk #(
    parameter int XLEN = 64,
    parameter int NB   = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            i_valid,
    input logic            i_ready,
    input logic            o_valid,
    input logic            o_ready,
    input logic            o_req,
    input logic            o_wb,
    input logic [XLEN-1:0] o_addr,
    input logic [NB-1:0]   o_be,
    input logic [XLEN-1:0] o_data,
    input logic [XLEN-1:0] o_wb_val,
    input logic            o_bad_form,
    input logic            o_misalign
);
    AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        o_valid && o_bad_form |-> !o_req && !o_wb && !o_misalign); // R9

    AST_MIS_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        o_valid && o_misalign |-> !o_req && !o_wb); // R10

    AST_WB_CARRIES_EA: assert property (@(posedge clk) disable iff (rst)
        o_valid && o_wb |-> o_req && (o_wb_val == o_addr)); // R7

    AST_IDLE_LANES_ZERO: assert property (@(posedge clk) disable iff (rst)
        o_valid && !o_req |-> (o_be == '0) && (o_data == '0)); // R6

    AST_REQ_HAS_LANE: assert property (@(posedge clk) disable iff (rst)
        o_valid && o_req |-> o_be[o_addr[2:0]]); // R6

    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (rst)
        i_valid && i_ready |=> o_valid); // R11

    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (rst)
        o_valid && !o_ready |=> o_valid && $stable(o_addr) && $stable(o_data) && $stable(o_be)); // R11

endmodule

bind store_req_fmt stfmt_chk #(.XLEN(XLEN), .NB(NB)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .i_valid    (i_valid),
    .i_ready    (i_ready),
    .o_valid    (o_valid),
    .o_ready    (o_ready),
    .o_req      (o_req),
    .o_wb       (o_wb),
    .o_addr     (o_addr),
    .o_be       (o_be),
    .o_data     (o_data),
    .o_wb_val   (o_wb_val),
    .o_bad_form (o_bad_form),
    .o_misalign (o_misalign)
);

// File: tb/sim_store_req_fmt.sv
module sim_store_req_fmt;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        i_valid = 1'b0;
    logic        i_ready;
    logic [63:0] i_src = '0;
    logic [4:0]  i_base_idx = '0;
    logic [63:0] i_base_val = '0;
    logic [63:0] i_index_val = '0;
    logic [15:0] i_disp = '0;
    logic        i_indexed = 1'b0;
    logic [1:0]  i_size = '0;
    logic        i_update = 1'b0;
    logic        i_brev = 1'b0;
    logic        o_valid;
    logic        o_ready = 1'b1;
    logic        o_req;
    logic [63:0] o_addr;
    logic [7:0]  o_be;
    logic [63:0] o_data;
    logic        o_wb;
    logic [4:0]  o_wb_idx;
    logic [63:0] o_wb_val;
    logic        o_bad_form;
    logic        o_misalign;

    always #2 clk = ~clk;

    store_req_fmt u0 (.*);

    typedef struct {
        logic        req;
        logic [63:0] addr;
        logic [7:0]  be;
        logic [63:0] data;
        logic        wb;
        logic [4:0]  wb_idx;
        logic        bad;
        logic        mis;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t model();
        exp_t e;
        logic [63:0] base, off, ea;
        logic [15:0] d;
        int n, o;
        n = 1 << i_size;
        base = (!i_update && i_base_idx == 0) ? 64'd0 : i_base_val;   // R2
        d = i_disp;
        if (i_size == 2'd3) d = d & 16'hFFFC;                           // R4
        off = i_indexed ? i_index_val : {{48{d[15]}}, d};              // R3
        ea = base + off;
        e.addr = ea;
        e.bad = (i_update && i_base_idx == 0) || (i_brev && !i_indexed) || (i_brev && i_update); // R9
        o = int'(ea[2:0]);
        e.mis = !e.bad && (o + n > 8);                                  // R10
        e.req = !e.bad && !e.mis;
        e.wb = e.req && i_update;                                       // R7
        e.wb_idx = i_base_idx;
        e.be = '0;
        e.data = '0;
        if (e.req) begin
            for (int j = 0; j < n; j++) begin
                logic [7:0] b;
                b = i_brev ? i_src[8*j +: 8] : i_src[8*(n-1-j) +: 8];  // R5 R8
                e.be[o+j] = 1'b1;
                e.data[63-8*(o+j) -: 8] = b;
            end
        end
        return e;
    endfunction

    task automatic compare_front();
        exp_t e;
        e = q.pop_front();
        chk("R3 addr", o_addr, e.addr);
        chk("R5 R8 data", o_data, e.data);
        chk("R6 be", {56'd0, o_be}, {56'd0, e.be});
        chk("R10 req", {63'd0, o_req}, {63'd0, e.req});
        chk("R7 wb", {63'd0, o_wb}, {63'd0, e.wb});
        if (e.wb) begin
            chk("R7 wb_idx", {59'd0, o_wb_idx}, {59'd0, e.wb_idx});
            chk("R7 wb_val", o_wb_val, e.addr);
        end
        chk("R9 bad_form", {63'd0, o_bad_form}, {63'd0, e.bad});
        chk("R10 misalign", {63'd0, o_misalign}, {63'd0, e.mis});
    endtask

    // one cycle: called just after a negedge, inputs already driven
    task automatic step();
        #1;
        chk("R11 ready", {63'd0, i_ready}, {63'd0, (q.size() == 0) || o_ready});
        if (o_valid && o_ready) compare_front();
        if (i_valid && i_ready) q.push_back(model());
        @(negedge clk);
        chk("R11 valid", {63'd0, o_valid}, {63'd0, q.size() != 0});
    endtask

    task automatic drive(input logic [63:0] src, input logic [4:0] ra, input logic [63:0] rav,
                         input logic [63:0] rbv, input logic [15:0] dsp, input logic idx,
                         input logic [1:0] sz, input logic upd, input logic rev);
        i_valid = 1'b1; i_src = src; i_base_idx = ra; i_base_val = rav; i_index_val = rbv;
        i_disp = dsp; i_indexed = idx; i_size = sz; i_update = upd; i_brev = rev;
        step();
        while (!(o_valid && q.size() != 0) && 0) step();
    endtask

    task automatic run();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 o_valid", {63'd0, o_valid}, 64'd0);
        chk("R1 i_ready", {63'd0, i_ready}, 64'd1);
        o_ready = 1'b1;
        // R2: base index 0, no update, base value ignored
        drive(64'h1122334455667788, 5'd0, 64'hFFFF_0000_0000_1000, 64'd0, 16'h0010, 1'b0, 2'd2, 1'b0, 1'b0);
        // R4: doubleword displacement with low bits set, negative
        drive(64'h0102030405060708, 5'd3, 64'h2000, 64'd0, 16'hFFF3, 1'b0, 2'd3, 1'b0, 1'b0);
        // R8: reversed word at offset 4
        drive(64'hAABBCCDD_11223344, 5'd2, 64'h100, 64'h4, 16'd0, 1'b1, 2'd2, 1'b0, 1'b1);
        // R8: reversed halfword at offset 6
        drive(64'h0000_0000_0000_BEEF, 5'd2, 64'h106, 64'h0, 16'd0, 1'b1, 2'd1, 1'b0, 1'b1);
        // R9: update with base index 0
        drive(64'h55, 5'd0, 64'h300, 64'd0, 16'd8, 1'b0, 2'd0, 1'b1, 1'b0);
        // R9: reversed with displacement, reversed with update
        drive(64'h55, 5'd4, 64'h300, 64'd0, 16'd8, 1'b0, 2'd1, 1'b0, 1'b1);
        drive(64'h55, 5'd4, 64'h300, 64'd8, 16'd0, 1'b1, 2'd1, 1'b1, 1'b1);
        // R10: word ending exactly at edge, then one byte past
        drive(64'hCAFEF00D, 5'd1, 64'h404, 64'd0, 16'd0, 1'b0, 2'd2, 1'b0, 1'b0);
        drive(64'hCAFEF00D, 5'd1, 64'h405, 64'd0, 16'd0, 1'b0, 2'd2, 1'b0, 1'b0);
        // R7: valid update, base index 0 substitution not applied
        drive(64'h77, 5'd9, 64'h8000, 64'h11, 16'd0, 1'b1, 2'd0, 1'b1, 1'b0);
        // random traffic with backpressure
        for (int i = 0; i < 1500; i++) begin
            logic [63:0] rv, xv;
            rv = {$urandom, $urandom};
            xv = {$urandom, $urandom};
            if ($urandom % 2 == 0) rv[2:0] = 3'd0;
            if ($urandom % 2 == 0) xv = xv & 64'h7;
            o_ready = ($urandom % 4 != 0);
            i_valid = ($urandom % 5 != 0);
            i_src = {$urandom, $urandom};
            i_base_idx = 5'($urandom % 4);
            i_base_val = rv;
            i_index_val = xv;
            i_disp = 16'($urandom);
            if ($urandom % 2 == 0) i_disp = i_disp & 16'h800F;
            i_indexed = 1'($urandom);
            i_size = 2'($urandom);
            i_update = ($urandom % 4 == 0);
            i_brev = ($urandom % 3 == 0);
            step();
        end
        i_valid = 1'b0;
        o_ready = 1'b1;
        repeat (3) step();
        chk("R11 drained", {63'd0, o_valid}, 64'd0);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (100000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule